// File: doc/BRIEF.md
# Flash In-System Programming Command Controller

This block lets software read, program and erase an embedded flash array one word at a time through a small register-mapped bus slave. Software loads an address, a data word and a 6-bit command, then writes the trigger bit. The controller first vets the request against the flash layout and the update permissions, and only then drives the array through a single-port request interface. The array is a behavioural memory in which reads take one cycle and program or page-erase take a fixed number of cycles.

The flash has three regions: a main application region, a loader region and a small configuration region. A boot-select bit records which region the code is running from. A request fails, and the array is left untouched, in any of these cases:
- the address is outside every region;
- the address is not word aligned;
- the command code is unknown;
- the running region would rewrite itself without permission;
- the configuration words would be changed without permission.

A failure sets a sticky fail flag. The control and trigger registers accept writes only while the protection unlock input is high.

The sequencer has these states and transitions:
- IDLE moves to CHECK on an accepted trigger.
- CHECK moves to FAILED when the request is illegal, and to ISSUE otherwise.
- ISSUE sends one request to the array and moves to WAIT.
- WAIT returns to IDLE when the array reports completion.
- FAILED sets the fail flag and returns to IDLE.
- A soft reset sends any state back to IDLE.

Top module: `fisp_ctrl`

## Requirements
- R1: Register offsets are: control 0x00, address 0x04, data 0x08, command 0x0C, trigger 0x10 and status 0x14. An accepted trigger is a write of 1 to trigger bit 0 while the block is idle. After an accepted trigger, trigger bit 0 and status bit 0 (busy) read 1 until the operation ends, then both read 0.
- R2: Control bit 0 is the enable. While it is 0, a trigger write is ignored: the trigger reads back 0, busy stays 0 and the array is unchanged.
- R3: Writes to the control register and to the trigger register take effect only while `prot_unlock` is 1.
- R4: Boot bit (control bit 1) equal to 0 means code runs from the main region (byte addresses 0 to MAIN_WORDS*4-1). In that case, a program or erase aimed at the main region while control bit 2 is 0 fails.
- R5: Boot bit equal to 1 means code runs from the loader region (LDR_BASE onward, LDR_WORDS words). In that case, a program or erase aimed at the loader region while control bit 3 is 0 fails.
- R6: A program or erase aimed at the configuration region (CFG_BASE onward, CFG_WORDS words) while control bit 4 is 0 fails. Reads of any region are never refused on permission grounds.
- R7: An address outside all three regions fails for every command. An address with bits [1:0] not equal to 00 also fails for every command.
- R8: Command codes are read 0x00, program 0x21 and page erase 0x22. Any other code fails.
- R9: A failure sets the fail flag, which is control bit 5 and is mirrored in status bit 1. The flag stays set until a write to control with bit 5 equal to 1. If that write lands in the same cycle as a hardware failure, the flag ends set.
- R10: A program stores the data register at the addressed word. A read loads the addressed word into the data register. A page erase sets all PAGE_WORDS words of the aligned page to all ones, which is also the array content after power-on reset. A failed operation leaves the array unchanged.
- R11: `rst_n` clears every register and loads the boot bit with the inverse of `boot_cfg`. `soft_rst` clears every register but leaves the boot bit as it was.
- R12: While busy, writes to address, data and command are ignored, and so are control writes to bits 0 to 4. A control write that clears the fail flag is still accepted while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| soft_rst | input | 1 | Synchronous CPU/system reset that keeps the boot bit |
| prot_unlock | input | 1 | High while protected registers may be written |
| boot_cfg | input | 1 | Configured boot selection; the boot bit loads its inverse |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |

## Verification
Two functions can fall in the same cycle: the hardware setting of the fail flag as the sequencer leaves FAILED, and a software write-one-to-clear of that flag. The bench issues a trigger with an illegal command, leaves one idle cycle, and then places a clear write exactly on the FAILED cycle. It expects the flag to read 1 afterwards. A second clear, issued later, must bring the flag back to 0.

// File: rtl/fisp_pkg.sv
package fisp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_ISSUE,
        ST_WAIT,
        ST_FAILED
    } fsm_t;

    typedef enum logic [1:0] {
        OP_READ,
        OP_PROG,
        OP_ERASE,
        OP_NONE
    } op_t;

    localparam logic [5:0] CMD_READ  = 6'h00;
    localparam logic [5:0] CMD_PROG  = 6'h21;
    localparam logic [5:0] CMD_ERASE = 6'h22;

    localparam logic [7:0] RA_CTRL = 8'h00;
    localparam logic [7:0] RA_ADDR = 8'h04;
    localparam logic [7:0] RA_DATA = 8'h08;
    localparam logic [7:0] RA_CMD  = 8'h0C;
    localparam logic [7:0] RA_GO   = 8'h10;
    localparam logic [7:0] RA_STAT = 8'h14;

    function automatic op_t decode_cmd(input logic [5:0] code);
        case (code)
            CMD_READ:  return OP_READ;
            CMD_PROG:  return OP_PROG;
            CMD_ERASE: return OP_ERASE;
            default:   return OP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/fisp_check.sv
module fisp_check
    import fisp_pkg::*;
#(
    parameter int          MAIN_WORDS = 256,
    parameter logic [31:0] LDR_BASE   = 32'h0001_0000,
    parameter int          LDR_WORDS  = 64,
    parameter logic [31:0] CFG_BASE   = 32'h0002_0000,
    parameter int          CFG_WORDS  = 4,
    parameter int          IW         = 9
) (
    input  logic [31:0]   addr,
    input  op_t           op,
    input  logic          boot,
    input  logic          main_upd,
    input  logic          ldr_upd,
    input  logic          cfg_upd,
    output logic          viol,
    output logic [IW-1:0] word_idx
);
    localparam logic [31:0] MAIN_END = 32'(MAIN_WORDS * 4);
    localparam logic [31:0] LDR_END  = LDR_BASE + 32'(LDR_WORDS * 4);
    localparam logic [31:0] CFG_END  = CFG_BASE + 32'(CFG_WORDS * 4);
    localparam logic [31:0] LDR_OFF  = 32'(MAIN_WORDS);
    localparam logic [31:0] CFG_OFF  = 32'(MAIN_WORDS + LDR_WORDS);

    logic in_main, in_ldr, in_cfg, modifies, perm_bad;

    always_comb begin
        in_main  = addr < MAIN_END;
        in_ldr   = (addr >= LDR_BASE) && (addr < LDR_END);
        in_cfg   = (addr >= CFG_BASE) && (addr < CFG_END);
        modifies = (op == OP_PROG) || (op == OP_ERASE);
        perm_bad = modifies && ((in_main && !boot && !main_upd) ||
                                (in_ldr  &&  boot && !ldr_upd)  ||
                                (in_cfg  && !cfg_upd));
        viol = (op == OP_NONE) || (addr[1:0] != 2'b00) ||
               !(in_main || in_ldr || in_cfg) || perm_bad;
        if (in_ldr)
            word_idx = IW'(LDR_OFF + ((addr - LDR_BASE) >> 2));
        else if (in_cfg)
            word_idx = IW'(CFG_OFF + ((addr - CFG_BASE) >> 2));
        else
            word_idx = IW'(addr >> 2);
    end
endmodule

// File: rtl/fisp_array.sv
module fisp_array
    import fisp_pkg::*;
#(
    parameter int WORDS      = 324,
    parameter int PAGE_WORDS = 4,
    parameter int OP_LAT     = 8,
    parameter int IW         = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          req,
    input  op_t           op,
    input  logic [IW-1:0] idx,
    input  logic [31:0]   wdata,
    output logic          done,
    output logic [31:0]   rdata
);
    localparam int CW = $clog2(OP_LAT + 1);

    logic [31:0]   mem [WORDS];
    logic [CW-1:0] cnt;
    op_t           op_q;
    logic [IW-1:0] idx_q;
    logic [31:0]   wd_q;
    logic [IW-1:0] page_base;

    assign page_base = idx_q & ~IW'(PAGE_WORDS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '1;
            cnt   <= '0;
            done  <= 1'b0;
            rdata <= '0;
            op_q  <= OP_NONE;
            idx_q <= '0;
            wd_q  <= '0;
        end else if (soft_rst) begin
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (req) begin
                cnt   <= (op == OP_READ) ? CW'(1) : CW'(OP_LAT);
                op_q  <= op;
                idx_q <= idx;
                wd_q  <= wdata;
            end else if (cnt != '0) begin
                cnt <= cnt - CW'(1);
                if (cnt == CW'(1)) begin
                    done <= 1'b1;
                    case (op_q)
                        OP_READ:  rdata <= mem[idx_q];
                        OP_PROG:  mem[idx_q] <= wd_q;
                        OP_ERASE: for (int p = 0; p < PAGE_WORDS; p++)
                                      mem[IW'(page_base + IW'(p))] <= '1;
                        default:  ;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/fisp_seq.sv
module fisp_seq
    import fisp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic start,
    input  logic viol,
    input  logic arr_done,
    output logic busy,
    output logic arr_req,
    output logic fail_set,
    output logic finish
);
    fsm_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        state <= ST_IDLE;
        else if (soft_rst) state <= ST_IDLE;
        else               state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_CHECK;
            ST_CHECK:  state_nx = viol ? ST_FAILED : ST_ISSUE;
            ST_ISSUE:  state_nx = ST_WAIT;
            ST_WAIT:   if (arr_done) state_nx = ST_IDLE;
            ST_FAILED: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        busy     = (state != ST_IDLE);
        arr_req  = (state == ST_ISSUE);
        fail_set = (state == ST_FAILED);
        finish   = (state == ST_WAIT) && arr_done;
    end
endmodule

// File: rtl/fisp_ctrl.sv
module fisp_ctrl
    import fisp_pkg::*;
#(
    parameter int          MAIN_WORDS = 256,
    parameter logic [31:0] LDR_BASE   = 32'h0001_0000,
    parameter int          LDR_WORDS  = 64,
    parameter logic [31:0] CFG_BASE   = 32'h0002_0000,
    parameter int          CFG_WORDS  = 4,
    parameter int          PAGE_WORDS = 4,
    parameter int          OP_LAT     = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_rst,
    input  logic        prot_unlock,
    input  logic        boot_cfg,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata
);
    localparam int TOTAL = MAIN_WORDS + LDR_WORDS + CFG_WORDS;
    localparam int IW    = $clog2(TOTAL);

    logic en_q, boot_q, main_upd_q, ldr_upd_q, cfg_upd_q, fail_q;
    logic [31:0] addr_q, data_q;
    logic [5:0]  cmd_q;
    logic busy, arr_req, fail_set, finish, viol, arr_done;
    logic [IW-1:0] word_idx;
    logic [31:0] arr_rdata;
    logic wr, wr_ctrl, start;
    op_t  op;

    assign op      = decode_cmd(cmd_q);
    assign wr      = bus_sel && bus_wr;
    assign wr_ctrl = wr && (bus_addr == RA_CTRL) && prot_unlock;
    assign start   = wr && (bus_addr == RA_GO) && prot_unlock &&
                     bus_wdata[0] && en_q && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0; main_upd_q <= 1'b0; ldr_upd_q <= 1'b0;
            cfg_upd_q <= 1'b0; fail_q <= 1'b0;
            addr_q <= '0; data_q <= '0; cmd_q <= '0;
        end else if (soft_rst) begin
            en_q <= 1'b0; main_upd_q <= 1'b0; ldr_upd_q <= 1'b0;
            cfg_upd_q <= 1'b0; fail_q <= 1'b0;
            addr_q <= '0; data_q <= '0; cmd_q <= '0;
        end else begin
            if (fail_set)                    fail_q <= 1'b1;
            else if (wr_ctrl && bus_wdata[5]) fail_q <= 1'b0;
            if (wr_ctrl && !busy) begin
                en_q       <= bus_wdata[0];
                main_upd_q <= bus_wdata[2];
                ldr_upd_q  <= bus_wdata[3];
                cfg_upd_q  <= bus_wdata[4];
            end
            if (wr && !busy && bus_addr == RA_ADDR) addr_q <= bus_wdata;
            if (wr && !busy && bus_addr == RA_CMD)  cmd_q  <= bus_wdata[5:0];
            if (finish && op == OP_READ)             data_q <= arr_rdata;
            else if (wr && !busy && bus_addr == RA_DATA) data_q <= bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         boot_q <= ~boot_cfg;
        else if (!soft_rst && wr_ctrl && !busy) boot_q <= bus_wdata[1];
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (bus_addr)
                RA_CTRL: bus_rdata = {26'b0, fail_q, cfg_upd_q, ldr_upd_q,
                                      main_upd_q, boot_q, en_q};
                RA_ADDR: bus_rdata = addr_q;
                RA_DATA: bus_rdata = data_q;
                RA_CMD:  bus_rdata = {26'b0, cmd_q};
                RA_GO:   bus_rdata = {31'b0, busy};
                RA_STAT: bus_rdata = {30'b0, fail_q, busy};
                default: bus_rdata = '0;
            endcase
        end
    end

    fisp_check #(
        .MAIN_WORDS(MAIN_WORDS), .LDR_BASE(LDR_BASE), .LDR_WORDS(LDR_WORDS),
        .CFG_BASE(CFG_BASE), .CFG_WORDS(CFG_WORDS), .IW(IW)
    ) check_i (
        .addr(addr_q), .op(op), .boot(boot_q), .main_upd(main_upd_q),
        .ldr_upd(ldr_upd_q), .cfg_upd(cfg_upd_q), .viol(viol),
        .word_idx(word_idx)
    );

    fisp_seq seq_i (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .start(start),
        .viol(viol), .arr_done(arr_done), .busy(busy), .arr_req(arr_req),
        .fail_set(fail_set), .finish(finish)
    );

    fisp_array #(
        .WORDS(TOTAL), .PAGE_WORDS(PAGE_WORDS), .OP_LAT(OP_LAT), .IW(IW)
    ) array_i (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .req(arr_req),
        .op(op), .idx(word_idx), .wdata(data_q), .done(arr_done),
        .rdata(arr_rdata)
    );
endmodule

// File: rtl/fisp_ctrl_chk.sv
module fisp_ctrl_chk
    import fisp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       soft_rst,
    input logic       prot_unlock,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic [7:0] bus_addr,
    input logic       go_bit,
    input logic       w1c_bit,
    input logic       busy,
    input logic       en_q,
    input logic       boot_q,
    input logic       fail_q,
    input logic       arr_req,
    input logic       viol
);
    // R1
    go_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_sel && bus_wr && bus_addr == RA_GO &&
                              prot_unlock && go_bit && en_q));

    // R2
    en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !busy) |=> !busy);

    // R3
    prot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!prot_unlock && !soft_rst) |=> ($stable(en_q) && $stable(boot_q)));

    // R7
    no_req_on_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_req |-> !viol);

    // R9
    fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fail_q) |-> $past(soft_rst || (bus_sel && bus_wr &&
                                bus_addr == RA_CTRL && prot_unlock && w1c_bit)));

    // R11
    boot_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> $stable(boot_q));
endmodule

bind fisp_ctrl fisp_ctrl_chk chk_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .prot_unlock(prot_unlock),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .go_bit(bus_wdata[0]), .w1c_bit(bus_wdata[5]), .busy(busy), .en_q(en_q),
    .boot_q(boot_q), .fail_q(fail_q), .arr_req(arr_req), .viol(viol)
);

// File: tb/fisp_ctrl_tb_top.sv
module fisp_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MAIN_WORDS = 256;
    localparam logic [31:0] LDR_BASE = 32'h0001_0000;
    localparam int LDR_WORDS = 64;
    localparam logic [31:0] CFG_BASE = 32'h0002_0000;
    localparam int CFG_WORDS = 4;
    localparam int PAGE_WORDS = 4;
    localparam int TOTAL = MAIN_WORDS + LDR_WORDS + CFG_WORDS;

    logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0, prot_unlock = 1'b1;
    logic boot_cfg = 1'b1, bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;

    int nchk = 0, nfail = 0;
    logic [31:0] model [TOTAL];

    always #(CLK_PERIOD/2) clk = ~clk;

    fisp_ctrl dut_i (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 200; i++) begin
            bus_read(8'h14, s);
            if (s[0] == 1'b0) return;
        end
        check("R1 busy timeout", s, 32'h0);
    endtask

    function automatic bit in_rng(logic [31:0] a, logic [31:0] b, int w);
        return (a >= b) && (a < b + 32'(w * 4));
    endfunction

    function automatic bit exp_viol(logic [31:0] a, logic [5:0] c, logic [4:0] ctl);
        bit m = (c == 6'h21) || (c == 6'h22);
        bit im = in_rng(a, 0, MAIN_WORDS);
        bit il = in_rng(a, LDR_BASE, LDR_WORDS);
        bit ic = in_rng(a, CFG_BASE, CFG_WORDS);
        if (!(c == 6'h00 || m)) return 1;
        if (a[1:0] != 2'b00 || !(im || il || ic)) return 1;
        if (m && im && !ctl[1] && !ctl[2]) return 1;
        if (m && il &&  ctl[1] && !ctl[3]) return 1;
        if (m && ic && !ctl[4]) return 1;
        return 0;
    endfunction

    function automatic int widx(logic [31:0] a);
        if (in_rng(a, LDR_BASE, LDR_WORDS)) return MAIN_WORDS + int'((a - LDR_BASE) >> 2);
        if (in_rng(a, CFG_BASE, CFG_WORDS)) return MAIN_WORDS + LDR_WORDS + int'((a - CFG_BASE) >> 2);
        return int'(a >> 2);
    endfunction

    task automatic run_op(logic [4:0] ctl, logic [31:0] a, logic [5:0] c,
                          logic [31:0] d, string tag);
        logic [31:0] s, rd;
        bit v;
        int ix;
        bus_write(8'h00, {26'b0, 1'b1, ctl});
        bus_write(8'h04, a);
        bus_write(8'h08, d);
        bus_write(8'h0C, {26'b0, c});
        bus_write(8'h10, 32'h1);
        wait_idle();
        v = exp_viol(a, c, ctl);
        bus_read(8'h14, s);
        check({tag, " fail flag"}, {31'b0, s[1]}, {31'b0, v});
        if (!v) begin
            ix = widx(a);
            if (c == 6'h21) model[ix] = d;
            else if (c == 6'h22)
                for (int p = 0; p < PAGE_WORDS; p++)
                    model[(ix & ~(PAGE_WORDS - 1)) + p] = '1;
            else begin
                bus_read(8'h08, rd);
                check("R10 read data", rd, model[ix]);
            end
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin : stim
        logic [31:0] r, a;
        logic [5:0]  c;
        logic [4:0]  ctl;
        int k;
        void'($urandom(32'd20240611));
        for (int i = 0; i < TOTAL; i++) model[i] = '1;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        bus_read(8'h00, r);
        check("R11 ctrl after power reset (boot=~cfg)", r, 32'h0);
        bus_read(8'h14, r);
        check("R1 status after reset", r, 32'h0);

        // R3 locked writes ignored
        prot_unlock = 1'b0;
        bus_write(8'h00, 32'h1F);
        bus_read(8'h00, r);
        check("R3 locked ctrl write", r, 32'h0);
        prot_unlock = 1'b1;

        // R2 trigger with enable at 0
        bus_write(8'h04, 32'h20);
        bus_write(8'h08, 32'hDEAD_0000);
        bus_write(8'h0C, 32'h21);
        bus_write(8'h10, 32'h1);
        bus_read(8'h10, r);
        check("R2 trigger ignored when disabled", r, 32'h0);
        bus_read(8'h14, r);
        check("R2 busy stays low", r, 32'h0);

        // R1 trigger, busy visible, then program
        bus_write(8'h00, 32'h05);
        bus_write(8'h10, 32'h1);
        bus_read(8'h10, r);
        check("R1 trigger reads 1 while busy", r, 32'h1);
        // R12 address write while busy is ignored
        bus_write(8'h04, 32'h44);
        bus_read(8'h04, r);
        check("R12 address frozen while busy", r, 32'h20);
        wait_idle();
        bus_read(8'h10, r);
        check("R1 trigger cleared at end", r, 32'h0);
        model[8] = 32'hDEAD_0000;
        run_op(5'b00101, 32'h20, 6'h00, 0, "R10 read after program");
        run_op(5'b00101, 32'h24, 6'h22, 0, "R10 page erase");
        run_op(5'b00101, 32'h20, 6'h00, 0, "R10 read after erase");

        // R7 misaligned, R8 bad command
        run_op(5'b00101, 32'h22, 6'h00, 0, "R7 misaligned");
        run_op(5'b00101, 32'h20, 6'h05, 0, "R8 unknown command");

        // R9 sticky and set-wins-over-clear
        bus_write(8'h0C, 32'h3F);
        bus_write(8'h10, 32'h1);
        bus_write(8'h00, 32'h25);
        wait_idle();
        bus_read(8'h00, r);
        check("R9 set wins over same-cycle clear", {31'b0, r[5]}, 32'h1);
        bus_read(8'h14, r);
        check("R9 status mirror", {31'b0, r[1]}, 32'h1);
        bus_write(8'h00, 32'h25);
        bus_read(8'h00, r);
        check("R9 write-one clears", {31'b0, r[5]}, 32'h0);

        // R11 soft reset keeps boot
        bus_write(8'h00, 32'h03);
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        bus_read(8'h00, r);
        check("R11 soft reset keeps boot", r, 32'h2);

        // R4 R5 R6 R7 R8 R10 random mix
        for (int n = 0; n < 400; n++) begin
            k = int'($urandom % 6);
            case (k)
                0: a = 32'($urandom % MAIN_WORDS) << 2;
                1: a = LDR_BASE + (32'($urandom % LDR_WORDS) << 2);
                2: a = CFG_BASE + (32'($urandom % CFG_WORDS) << 2);
                3: a = (32'($urandom % MAIN_WORDS) << 2) | 32'(1 + $urandom % 3);
                4: a = 32'(MAIN_WORDS * 4) + (32'($urandom % 16) << 2);
                default: a = CFG_BASE + 32'(CFG_WORDS * 4) + (32'($urandom % 16) << 2);
            endcase
            case ($urandom % 7)
                0, 1: c = 6'h00;
                2, 3: c = 6'h21;
                4:    c = 6'h22;
                default: begin
                    c = 6'($urandom);
                    if (c == 6'h00 || c == 6'h21 || c == 6'h22) c = 6'h10;
                end
            endcase
            ctl = {4'($urandom), 1'b1};
            run_op(ctl, a, c, $urandom, "R4 R5 R6 R7 R8 random");
        end

        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule